// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block keeps a microprogram counter for each of up to sixteen tasks and works out where each task goes next. The current microinstruction supplies a NEXT field. That field is ORed with a small modifier that the *previous* instruction of the same task left behind, and the result becomes the task's new counter value. Branch functions never redirect the jump that contains them. They only fill the modifier for the following instruction of that task.

A branch function in the current instruction can set the modifier from one of several sources: a zero test on the bus, the sign of the shifter output, a zero test on the shifter output, a dispatch on the low bits of the bus, or a carry bit. The carry is latched whenever L is loaded, so the carry branch sees the carry of the most recent L load, not the current one. A memory access that finds memory not ready suspends the cycle completely. A soft reset sends every counter back to its task number and leaves all other state alone.

The caller presents the active task number and the current instruction's fields each cycle. It reads back the selected task's counter (the address to fetch) and the combinational next address.

Top module: `useq_next_addr`

## Requirements
- R1: After a synchronous active-low reset, each task's counter equals its own task number, every modifier is 0 and the latched carry is 0.
- R2: In a cycle that is not stalled and not soft-reset, the active task's counter is loaded with `next_field | modifier`, where the modifier is the one held for that task. `next_upc` shows this value combinationally.
- R3: Branch code 1 (bus-zero) sets the task's modifier to 1 when `bus_val` is zero, and to 0 otherwise.
- R4: Branch code 2 (shift-negative) sets the modifier to 1 when bit 15 of `shift_out` is 1, and to 0 otherwise.
- R5: Branch code 3 (shift-zero) sets the modifier to 1 when `shift_out` is zero, and to 0 otherwise.
- R6: Branch code 4 (dispatch) loads the modifier with `bus_val[9:0]`.
- R7: Branch code 5 (carry) loads the modifier with the latched carry as it stood before this cycle. The latch takes `alu_carry` only in cycles that assert `load_l` and are neither stalled nor soft-reset.
- R8: Branch code 0 (or any unused code) leaves a modifier of 0, so a modifier affects only one following instruction.
- R9: When `mem_req` is 1 and `mem_ready` is 0, `stall` is 1 and no counter, modifier or carry latch changes. This includes a soft reset presented in the same cycle.
- R10: A soft reset in a non-stalled cycle sets every task's counter to its task number instead of loading NEXT. Modifiers and the carry latch keep their values.
- R11: Counters and modifiers of tasks other than the active one are not changed by a normal cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| task_id | input | 4 | Active task number |
| next_field | input | 10 | NEXT field of the current microinstruction |
| br_func | input | 3 | Branch function code (0 none, 1 bus-zero, 2 shift-negative, 3 shift-zero, 4 dispatch, 5 carry) |
| bus_val | input | 16 | Current bus value |
| shift_out | input | 16 | Shifter output computed from L at cycle start |
| load_l | input | 1 | Current instruction loads L |
| alu_carry | input | 1 | ALU carry of the current instruction |
| mem_req | input | 1 | Current instruction needs memory |
| mem_ready | input | 1 | Memory can accept the access |
| soft_rst | input | 1 | Soft reset request |
| cur_upc | output | 10 | Counter of the active task |
| next_upc | output | 10 | NEXT ORed with the active task's modifier |
| stall | output | 1 | Cycle suspended waiting for memory |

## Verification
`stall` and `next_upc` are combinational and are checked one time unit after the inputs are driven, before any edge. Counters, modifiers and the carry latch change at the first rising edge after the stimulus. They are read one time unit after that edge, by selecting the task through `task_id` and reading `cur_upc`. A modifier is read by driving a zero NEXT and reading `next_upc`. A modifier takes one edge to be written and becomes visible at the next consumption. So each branch check first issues the branching instruction, then inspects `next_upc` without clocking.

// File: rtl/useq_pkg.sv
// Package: shared widths and branch function encodings for the sequencer.
// Assumes the branch code is 3 bits; unused codes act as "no branch".
package useq_pkg;
    typedef enum logic [2:0] {
        BR_NONE       = 3'd0,
        BR_BUS_ZERO   = 3'd1,
        BR_SHIFT_NEG  = 3'd2,
        BR_SHIFT_ZERO = 3'd3,
        BR_DISPATCH   = 3'd4,
        BR_CARRY      = 3'd5
    } br_func_e;
endpackage

// File: rtl/useq_branch_eval.sv
// Module: evaluates the branch function of the current instruction into the
// modifier value for the next instruction, and keeps the carry latched at the
// last L load. Assumes DATA_W >= ADDR_W and that the sign bit is DATA_W-1.
module useq_branch_eval
    import useq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,        // cycle commits (not stalled, not soft reset)
    input  logic [2:0]        br_func,
    input  logic [DATA_W-1:0] bus_val,
    input  logic [DATA_W-1:0] shift_out,
    input  logic              load_l,
    input  logic              alu_carry,
    output logic [ADDR_W-1:0] mod_new,
    output logic              carry_q
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    br_func_e func;
    assign func = br_func_e'(br_func);

    // Purpose: select the modifier source named by the branch function.
    always_comb begin
        mod_new = '0;
        case (func)
            BR_BUS_ZERO:   mod_new = (bus_val == '0) ? ONE : '0;
            BR_SHIFT_NEG:  mod_new = shift_out[DATA_W-1] ? ONE : '0;
            BR_SHIFT_ZERO: mod_new = (shift_out == '0) ? ONE : '0;
            BR_DISPATCH:   mod_new = bus_val[ADDR_W-1:0];
            BR_CARRY:      mod_new = ADDR_W'(carry_q);
            default:       mod_new = '0;
        endcase
    end

    // Purpose: capture the ALU carry whenever a committed instruction loads L.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (upd && load_l)
            carry_q <= alu_carry;
    end

    assert_carry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd && load_l) |=> $stable(carry_q));
    assert_carry_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && load_l) |=> carry_q == $past(alu_carry));
endmodule

// File: rtl/useq_task_state.sv
// Module: per-task microprogram counters and pending modifiers. On a committed
// cycle the selected task takes the new address and modifier; a soft reset
// returns every counter to its task number. Assumes ADDR_W >= TASK_W.
module useq_task_state #(
    parameter int ADDR_W = 10,
    parameter int TASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,        // cycle not stalled
    input  logic              soft_rst,
    input  logic [TASK_W-1:0] task_sel,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [ADDR_W-1:0] mod_new,
    output logic [ADDR_W-1:0] cur_pc,
    output logic [ADDR_W-1:0] cur_mod
);
    localparam int NUM_TASKS = 1 << TASK_W;

    logic [ADDR_W-1:0] pc_q  [NUM_TASKS];
    logic [ADDR_W-1:0] mod_q [NUM_TASKS];

    assign cur_pc  = pc_q[task_sel];
    assign cur_mod = mod_q[task_sel];

    // Purpose: update counters and modifiers of all tasks.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_TASKS; i++) begin
            if (!rst_n) begin
                pc_q[i]  <= ADDR_W'(i);
                mod_q[i] <= '0;
            end else if (adv) begin
                if (soft_rst)
                    pc_q[i] <= ADDR_W'(i);
                else if (task_sel == TASK_W'(i)) begin
                    pc_q[i]  <= next_addr;
                    mod_q[i] <= mod_new;
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_TASKS; g++) begin : g_chk
        assert_pc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && !soft_rst && task_sel == TASK_W'(g)) |=> pc_q[g] == $past(next_addr));
        assert_mod_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && !soft_rst && task_sel == TASK_W'(g)) |=> mod_q[g] == $past(mod_new));
        assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !adv |=> ($stable(pc_q[g]) && $stable(mod_q[g])));
        assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && soft_rst) |=> (pc_q[g] == ADDR_W'(g) && $stable(mod_q[g])));
        assert_other_task_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!soft_rst && task_sel != TASK_W'(g)) |=> ($stable(pc_q[g]) && $stable(mod_q[g])));
    end
endmodule

// File: rtl/useq_next_addr.sv
// Module: top of the next-address sequencer. Detects memory stalls, forms the
// next address from NEXT and the pending modifier, and drives the branch
// evaluator and per-task state. Assumes one instruction per cycle.
module useq_next_addr #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 16,
    parameter int TASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TASK_W-1:0] task_id,
    input  logic [ADDR_W-1:0] next_field,
    input  logic [2:0]        br_func,
    input  logic [DATA_W-1:0] bus_val,
    input  logic [DATA_W-1:0] shift_out,
    input  logic              load_l,
    input  logic              alu_carry,
    input  logic              mem_req,
    input  logic              mem_ready,
    input  logic              soft_rst,
    output logic [ADDR_W-1:0] cur_upc,
    output logic [ADDR_W-1:0] next_upc,
    output logic              stall
);
    logic              adv;
    logic              upd;
    logic [ADDR_W-1:0] mod_new;
    logic [ADDR_W-1:0] cur_mod;
    logic              carry_q;

    // Purpose: stall detection and commit qualifiers.
    always_comb begin
        stall = mem_req && !mem_ready;
        adv   = !stall;
        upd   = adv && !soft_rst;
    end

    assign next_upc = next_field | cur_mod;

    useq_branch_eval #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_branch (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .br_func   (br_func),
        .bus_val   (bus_val),
        .shift_out (shift_out),
        .load_l    (load_l),
        .alu_carry (alu_carry),
        .mod_new   (mod_new),
        .carry_q   (carry_q)
    );

    useq_task_state #(.ADDR_W(ADDR_W), .TASK_W(TASK_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .soft_rst  (soft_rst),
        .task_sel  (task_id),
        .next_addr (next_upc),
        .mod_new   (mod_new),
        .cur_pc    (cur_upc),
        .cur_mod   (cur_mod)
    );

    assert_carry_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(carry_q));
    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !soft_rst) |=> cur_upc == $past(next_upc) || task_id != $past(task_id));
endmodule

// File: tb/useq_next_addr_tb.sv
module useq_next_addr_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  task_id;
    logic [9:0]  next_field;
    logic [2:0]  br_func;
    logic [15:0] bus_val;
    logic [15:0] shift_out;
    logic        load_l;
    logic        alu_carry;
    logic        mem_req;
    logic        mem_ready;
    logic        soft_rst;
    logic [9:0]  cur_upc;
    logic [9:0]  next_upc;
    logic        stall;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_next_addr u_dut (
        .clk(clk), .rst_n(rst_n), .task_id(task_id), .next_field(next_field),
        .br_func(br_func), .bus_val(bus_val), .shift_out(shift_out),
        .load_l(load_l), .alu_carry(alu_carry), .mem_req(mem_req),
        .mem_ready(mem_ready), .soft_rst(soft_rst), .cur_upc(cur_upc),
        .next_upc(next_upc), .stall(stall)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        br_func = 3'd0; bus_val = 16'hFFFF; shift_out = 16'h1234;
        load_l = 0; alu_carry = 0; mem_req = 0; mem_ready = 1; soft_rst = 0;
    endtask

    // One committed instruction for task t, then wait past the edge.
    task automatic issue(input int t, input int nxt, input int f,
                         input int bus, input int sh, input bit ll, input bit cy);
        idle_inputs();
        task_id = 4'(t); next_field = 10'(nxt); br_func = 3'(f);
        bus_val = 16'(bus); shift_out = 16'(sh); load_l = ll; alu_carry = cy;
        @(posedge clk); #1;
    endtask

    task automatic peek_pc(input int t, output int v);
        idle_inputs(); task_id = 4'(t); next_field = 10'h0; #1; v = cur_upc;
    endtask

    task automatic peek_next(input int t, input int nxt, output int v);
        idle_inputs(); task_id = 4'(t); next_field = 10'(nxt); #1; v = next_upc;
    endtask

    task automatic test_reset();
        int v;
        peek_pc(0, v);  chk("R1 pc task0", v, 0);
        peek_pc(5, v);  chk("R1 pc task5", v, 5);
        peek_pc(15, v); chk("R1 pc task15", v, 15);
        peek_next(5, 0, v); chk("R1 mod task5", v, 0);
    endtask

    task automatic test_next();
        int v;
        issue(2, 'h155, 0, 0, 0, 0, 0);
        peek_pc(2, v); chk("R2 pc loads NEXT", v, 'h155);
        peek_next(2, 'h2AA, v); chk("R2 next_upc", v, 'h2AA);
    endtask

    task automatic test_bus_zero();
        int v;
        issue(1, 'h100, 1, 0, 1, 0, 0);
        peek_next(1, 'h100, v); chk("R3 bus zero sets mod", v, 'h101);
        issue(1, 'h100, 0, 0, 0, 0, 0);
        peek_pc(1, v); chk("R2 pc uses mod", v, 'h101);
        peek_next(1, 0, v); chk("R8 mod consumed", v, 0);
        issue(1, 0, 1, 0, 1, 0, 0);
        issue(1, 0, 1, 'h0010, 1, 0, 0);
        peek_next(1, 0, v); chk("R3 bus nonzero clears mod", v, 0);
    endtask

    task automatic test_shift();
        int v;
        issue(1, 0, 2, 1, 'h8000, 0, 0);
        peek_next(1, 0, v); chk("R4 negative", v, 1);
        issue(1, 0, 2, 1, 'h7FFF, 0, 0);
        peek_next(1, 0, v); chk("R4 non-negative", v, 0);
        issue(1, 0, 3, 1, 0, 0, 0);
        peek_next(1, 0, v); chk("R5 shift zero", v, 1);
        issue(1, 0, 3, 1, 1, 0, 0);
        peek_next(1, 0, v); chk("R5 shift nonzero", v, 0);
    endtask

    task automatic test_dispatch();
        int v;
        issue(1, 0, 4, 'hABCD, 0, 0, 0);
        peek_next(1, 0, v); chk("R6 dispatch low bits", v, 'h3CD);
        peek_next(1, 'h030, v); chk("R6 dispatch OR", v, 'h3FD);
        issue(1, 'h030, 0, 0, 0, 0, 0);
        peek_pc(1, v); chk("R6 dispatch target", v, 'h3FD);
    endtask

    task automatic test_carry();
        int v;
        issue(3, 0, 0, 0, 0, 1, 1);
        issue(3, 0, 5, 0, 0, 1, 0);
        peek_next(3, 0, v); chk("R7 uses previous latched carry", v, 1);
        issue(3, 0, 5, 0, 0, 0, 1);
        peek_next(3, 0, v); chk("R7 latch updated by L load", v, 0);
        issue(3, 0, 5, 0, 0, 0, 1);
        peek_next(3, 0, v); chk("R7 no update without L load", v, 0);
    endtask

    task automatic test_stall();
        int v;
        issue(4, 'h050, 1, 0, 1, 0, 0);
        idle_inputs();
        task_id = 4'd4; next_field = 10'h3FF; br_func = 3'd4; bus_val = 16'h03FF;
        load_l = 1; alu_carry = 1; soft_rst = 1; mem_req = 1; mem_ready = 0;
        #1; chk("R9 stall asserted", int'(stall), 1);
        @(posedge clk); #1;
        peek_pc(4, v); chk("R9 pc held", v, 'h050);
        peek_next(4, 0, v); chk("R9 mod held", v, 1);
        peek_pc(7, v); chk("R9 soft reset ignored", v, 7);
        issue(4, 0, 5, 0, 0, 0, 0);
        peek_next(4, 0, v); chk("R9 carry latch held", v, 0);
        peek_pc(4, v); chk("R9 pc after resume", v, 1);
        idle_inputs();
        task_id = 4'd4; next_field = 10'h123; mem_req = 1; mem_ready = 1;
        #1; chk("R9 no stall when ready", int'(stall), 0);
        @(posedge clk); #1;
        peek_pc(4, v); chk("R9 ready access proceeds", v, 'h123);
    endtask

    task automatic test_soft();
        int v;
        issue(6, 'h200, 0, 0, 0, 0, 0);
        issue(7, 'h010, 1, 0, 1, 0, 0);
        idle_inputs();
        task_id = 4'd6; next_field = 10'h111; br_func = 3'd1; bus_val = 16'h0;
        soft_rst = 1;
        @(posedge clk); #1;
        peek_pc(6, v); chk("R10 active task counter", v, 6);
        peek_pc(7, v); chk("R10 other task counter", v, 7);
        peek_pc(4, v); chk("R10 task4 counter", v, 4);
        peek_next(7, 0, v); chk("R10 modifier kept", v, 1);
        peek_next(6, 0, v); chk("R10 no modifier update", v, 0);
    endtask

    task automatic test_isolation();
        int v;
        issue(8, 'h0AA, 0, 0, 0, 0, 0);
        issue(9, 'h0F0, 1, 0, 1, 0, 0);
        peek_pc(8, v); chk("R11 other pc untouched", v, 'h0AA);
        peek_next(8, 0, v); chk("R11 other mod untouched", v, 0);
        peek_next(9, 0, v); chk("R11 own mod set", v, 1);
    endtask

    initial begin
        idle_inputs();
        task_id = 0; next_field = 0; rst_n = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        test_reset();
        test_next();
        test_bus_zero();
        test_shift();
        test_dispatch();
        test_carry();
        test_stall();
        test_soft();
        test_isolation();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule